// File: doc/BRIEF.md
# Tagged Geometric-History Direction Predictor

This block predicts whether a conditional branch is taken. A table of 2-bit counters indexed by the program counter gives a fallback guess. Above it sit several tagged tables. Each tagged table is indexed by hashing the program counter with a slice of the global outcome history, and the slice length doubles from one table to the next. A partial tag in each entry ties it to the branch and history that created it. The longest-history table whose tag matches gives the prediction. When no tag matches, the counter table decides.

Lookup is combinational on the word address `pcWord`. In the same cycle, the caller may raise `updValid` with the resolved outcome of that branch. At the next clock edge, the tables are trained using the history that produced the prediction, and the outcome is shifted into the history. A wrong prediction claims an entry in a longer table, so a branch that needs more context gets it next time.

Top module: `tage_top`

## Requirements
- R1: A 16-bit global history register resets to zero. On each cycle with `updValid` high it shifts left by one and loads `updTaken` into bit 0. It holds its value otherwise. Tagged table k (1 to 3) uses the lowest 4, 8 and 16 history bits, so the lengths double from table to table.
- R2: Fold an L-bit history to w bits by XORing history bit j into result bit j mod w. Table k has 64 entries. Its index is `pcWord[5:0]` XOR the fold to 6 bits. Its 8-bit tag is `pcWord[13:6]` XOR the fold to 8 bits XOR (the fold to 7 bits shifted left by one, truncated to 8 bits).
- R3: A tagged table hits when its indexed entry is valid and its stored tag equals the computed tag. `provId` gives the highest-numbered hitting table, or 0 when none hits, and `predTaken` follows that provider.
- R4: The fallback table has 256 two-bit counters indexed by `pcWord[7:0]`, all reset to 1. It predicts taken when the counter is 2 or more.
- R5: After reset every tagged entry is invalid, so `predTaken` is 0 and `provId` is 0 for any `pcWord`.
- R6: A tagged entry holds a 3-bit two's-complement counter (-4 to 3) and predicts taken when the counter is 0 or more. On an update, the provider's counter steps toward the outcome and saturates. The fallback counter (0 to 3) is trained only when no tagged table hits.
- R7: The alternate prediction comes from the next lower hitting table, or from the fallback table if there is none. When a tagged provider was right and the alternate differed, the provider's useful bit is set.
- R8: On a wrong prediction, the lowest table above the provider whose indexed entry has a clear useful bit is written. The entry becomes valid, takes the computed tag, gets counter 0 if taken or -1 (3'b111) if not, and gets a clear useful bit. Nothing is allocated when table 3 is the provider.
- R9: On a wrong prediction where every table above the provider has its indexed useful bit set, those useful bits are cleared and no entry is allocated.
- R10: With `updValid` low, no table, counter or history state changes, whatever `updTaken` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pcWord | input | 14 | Branch address bits 15..2 |
| updValid | input | 1 | Resolve the branch at `pcWord` this cycle |
| updTaken | input | 1 | Resolved outcome |
| predTaken | output | 1 | Predicted direction |
| provId | output | 2 | Providing table: 0 fallback, 1..3 tagged |

## Verification
The checks assume that an update is always for the branch currently on `pcWord`, and that it happens in the same cycle as the lookup it trains. The history used for training is therefore the same history that formed the prediction. The stimulus drives address and outcome together on the falling edge and holds them through the rising edge. It never resolves a branch other than the one being looked up. The bench's model steps in lockstep with the design, one update per edge. Every strobe-level property, such as single-table allocation and allocation excluding the useful-bit clear, is checked only while reset is low.

// File: rtl/tage_pkg.sv
package tage_pkg;
  localparam int PC_W       = 16;
  localparam int NUM_TAGGED = 3;
  localparam int HIST_LEN   = 16;
  localparam int BASE_HIST  = 4;
  localparam int IDX_W      = 6;
  localparam int TAG_W      = 8;
  localparam int CTR_W      = 3;
  localparam int BASE_IDX_W = 8;
  localparam int PROV_W     = $clog2(NUM_TAGGED + 1);

  typedef struct packed {
    logic                  shiftHist;
    logic                  taken;
    logic                  trainBase;
    logic                  trainTag;
    logic [NUM_TAGGED-1:0] tagSel;
    logic                  setUseful;
    logic [NUM_TAGGED-1:0] allocSel;
    logic [NUM_TAGGED-1:0] clrUseful;
  } tageStrobeT;

  function automatic logic [IDX_W-1:0] foldIdx(input logic [HIST_LEN-1:0] h, input int len);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int j = 0; j < HIST_LEN; j++)
      if (j < len) r[j % IDX_W] = r[j % IDX_W] ^ h[j];
    return r;
  endfunction

  function automatic logic [TAG_W-1:0] foldTag(input logic [HIST_LEN-1:0] h, input int len);
    logic [TAG_W-1:0] a;
    logic [TAG_W-2:0] b;
    a = '0;
    b = '0;
    for (int j = 0; j < HIST_LEN; j++) begin
      if (j < len) begin
        a[j % TAG_W]       = a[j % TAG_W] ^ h[j];
        b[j % (TAG_W - 1)] = b[j % (TAG_W - 1)] ^ h[j];
      end
    end
    return a ^ {b, 1'b0};
  endfunction
endpackage

// File: rtl/tage_datapath.sv
module tage_datapath
  import tage_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [PC_W-1:2]                  pcWord,
  input  tageStrobeT                       st,
  output logic [NUM_TAGGED-1:0]            hitVec,
  output logic [NUM_TAGGED-1:0][CTR_W-1:0] ctrVec,
  output logic [NUM_TAGGED-1:0]            useVec,
  output logic [1:0]                       baseCtr
);
  localparam int NE     = 1 << IDX_W;
  localparam int BASE_N = 1 << BASE_IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = {1'b0, {(CTR_W-1){1'b1}}};
  localparam logic [CTR_W-1:0] CTR_MIN = {1'b1, {(CTR_W-1){1'b0}}};

  logic [HIST_LEN-1:0] ghr;

  always_ff @(posedge clk) begin
    if (!rstN) ghr <= '0;
    else if (st.shiftHist) ghr <= {ghr[HIST_LEN-2:0], st.taken};
  end

  // Fallback counter table
  logic [1:0] baseMem [BASE_N];
  logic [BASE_IDX_W-1:0] baseIdx;
  assign baseIdx = pcWord[BASE_IDX_W+1:2];
  assign baseCtr = baseMem[baseIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < BASE_N; e++) baseMem[e] <= 2'b01;
    end else if (st.trainBase) begin
      if (st.taken && baseMem[baseIdx] != 2'b11) baseMem[baseIdx] <= baseMem[baseIdx] + 2'b01;
      else if (!st.taken && baseMem[baseIdx] != 2'b00) baseMem[baseIdx] <= baseMem[baseIdx] - 2'b01;
    end
  end

  // Tagged tables, history length doubling per table
  for (genvar t = 0; t < NUM_TAGGED; t++) begin : gTab
    localparam int LEN = BASE_HIST << t;
    logic [NE-1:0]    vld;
    logic [NE-1:0]    useMem;
    logic [TAG_W-1:0] tagMem [NE];
    logic [CTR_W-1:0] ctrMem [NE];
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    assign idx = pcWord[IDX_W+1:2] ^ foldIdx(ghr, LEN);
    assign tag = pcWord[TAG_W+IDX_W+1:IDX_W+2] ^ foldTag(ghr, LEN);
    assign hitVec[t] = vld[idx] && (tagMem[idx] == tag);
    assign ctrVec[t] = ctrMem[idx];
    assign useVec[t] = useMem[idx];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld    <= '0;
        useMem <= '0;
        for (int e = 0; e < NE; e++) begin
          tagMem[e] <= '0;
          ctrMem[e] <= '0;
        end
      end else if (st.allocSel[t]) begin
        vld[idx]    <= 1'b1;
        useMem[idx] <= 1'b0;
        tagMem[idx] <= tag;
        ctrMem[idx] <= st.taken ? '0 : '1;
      end else begin
        if (st.clrUseful[t]) useMem[idx] <= 1'b0;
        else if (st.setUseful && st.tagSel[t]) useMem[idx] <= 1'b1;
        if (st.trainTag && st.tagSel[t]) begin
          if (st.taken && ctrMem[idx] != CTR_MAX) ctrMem[idx] <= ctrMem[idx] + 1'b1;
          else if (!st.taken && ctrMem[idx] != CTR_MIN) ctrMem[idx] <= ctrMem[idx] - 1'b1;
        end
      end
    end
  end

  // R1
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.shiftHist |=> (ghr[0] == $past(st.taken)) && (ghr[HIST_LEN-1:1] == $past(ghr[HIST_LEN-2:0])));
  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !st.shiftHist |=> $stable(ghr));
endmodule

// File: rtl/tage_ctrl.sv
module tage_ctrl
  import tage_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             updValid,
  input  logic                             updTaken,
  input  logic [NUM_TAGGED-1:0]            hitVec,
  input  logic [NUM_TAGGED-1:0][CTR_W-1:0] ctrVec,
  input  logic [NUM_TAGGED-1:0]            useVec,
  input  logic [1:0]                       baseCtr,
  output tageStrobeT                       st,
  output logic                             predTaken,
  output logic [PROV_W-1:0]                provId
);
  logic provPred, altPred, mispred, found;
  int   provIdx;

  always_comb begin
    provIdx  = -1;
    provPred = baseCtr[1];
    altPred  = baseCtr[1];
    for (int t = 0; t < NUM_TAGGED; t++) begin
      if (hitVec[t]) begin
        altPred  = provPred;
        provPred = !ctrVec[t][CTR_W-1];
        provIdx  = t;
      end
    end
    predTaken = provPred;
    provId    = PROV_W'(provIdx + 1);
    mispred   = provPred != updTaken;

    st           = '0;
    st.taken     = updTaken;
    st.shiftHist = updValid;
    st.trainBase = updValid && (provIdx < 0);
    st.trainTag  = updValid && (provIdx >= 0);
    for (int t = 0; t < NUM_TAGGED; t++) st.tagSel[t] = (t == provIdx);
    st.setUseful = updValid && (provIdx >= 0) && !mispred && (altPred != provPred);

    found = 1'b0;
    for (int t = 0; t < NUM_TAGGED; t++) begin
      if (updValid && mispred && t > provIdx && !found && !useVec[t]) begin
        st.allocSel[t] = 1'b1;
        found = 1'b1;
      end
    end
    for (int t = 0; t < NUM_TAGGED; t++)
      st.clrUseful[t] = updValid && mispred && !found && (t > provIdx);
  end

  // R8
  alloc_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st.allocSel));
  // R9
  alloc_clr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !((|st.allocSel) && (|st.clrUseful)));
  // R3
  prov_longest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec >> provId) == '0);
  // R3
  prov_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (provId != '0) |-> hitVec[provId - 1'b1]);
endmodule

// File: rtl/tage_top.sv
module tage_top
  import tage_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:2]   pcWord,
  input  logic              updValid,
  input  logic              updTaken,
  output logic              predTaken,
  output logic [PROV_W-1:0] provId
);
  tageStrobeT                       st;
  logic [NUM_TAGGED-1:0]            hitVec;
  logic [NUM_TAGGED-1:0][CTR_W-1:0] ctrVec;
  logic [NUM_TAGGED-1:0]            useVec;
  logic [1:0]                       baseCtr;

  tage_datapath uDp (
    .clk(clk), .rstN(rstN), .pcWord(pcWord), .st(st),
    .hitVec(hitVec), .ctrVec(ctrVec), .useVec(useVec), .baseCtr(baseCtr)
  );

  tage_ctrl uCtl (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updTaken(updTaken),
    .hitVec(hitVec), .ctrVec(ctrVec), .useVec(useVec), .baseCtr(baseCtr),
    .st(st), .predTaken(predTaken), .provId(provId)
  );
endmodule

// File: tb/sim_tage_top.sv
module sim_tage_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] pcWord = '0;
  logic        updValid = 1'b0;
  logic        updTaken = 1'b0;
  logic        predTaken;
  logic [1:0]  provId;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tage_top u0 (.clk(clk), .rstN(rstN), .pcWord(pcWord), .updValid(updValid),
               .updTaken(updTaken), .predTaken(predTaken), .provId(provId));

  // reference model built from the requirements
  bit          mVld [3][64];
  bit          mU   [3][64];
  int          mTag [3][64];
  int          mCtr [3][64];
  int          mBase[256];
  logic [15:0] mGhr;
  bit          evUse, evAlloc, evClr;

  localparam logic [14:0] VEC [16] = '{
    {14'h0123, 1'b1}, {14'h0123, 1'b1}, {14'h2a40, 1'b0}, {14'h0123, 1'b0},
    {14'h1f07, 1'b1}, {14'h2a40, 1'b1}, {14'h0123, 1'b1}, {14'h3c11, 1'b0},
    {14'h1f07, 1'b0}, {14'h0123, 1'b1}, {14'h2a40, 1'b0}, {14'h3c11, 1'b1},
    {14'h0550, 1'b1}, {14'h0123, 1'b0}, {14'h1f07, 1'b1}, {14'h0550, 1'b0}
  };

  function automatic int fold(input logic [15:0] h, input int len, input int w);
    int r = 0;
    for (int j = 0; j < len; j++) r = r ^ (int'(h[j]) << (j % w));
    return r;
  endfunction

  function automatic int mIdx(input logic [13:0] p, input int k);
    return (int'(p[5:0]) ^ fold(mGhr, 4 << k, 6)) & 63;
  endfunction

  function automatic int mTg(input logic [13:0] p, input int k);
    return (int'(p[13:6]) ^ fold(mGhr, 4 << k, 8) ^ (fold(mGhr, 4 << k, 7) << 1)) & 255;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 3; k++)
      for (int e = 0; e < 64; e++) begin
        mVld[k][e] = 0; mU[k][e] = 0; mTag[k][e] = 0; mCtr[k][e] = 0;
      end
    for (int e = 0; e < 256; e++) mBase[e] = 1;
    mGhr = '0;
  endtask

  task automatic modelLook(input logic [13:0] p, output bit pred, output int prov, output bit alt);
    pred = mBase[p[7:0]] >= 2;
    alt  = pred;
    prov = 0;
    for (int k = 0; k < 3; k++) begin
      if (mVld[k][mIdx(p, k)] && mTag[k][mIdx(p, k)] == mTg(p, k)) begin
        alt  = pred;
        pred = mCtr[k][mIdx(p, k)] >= 0;
        prov = k + 1;
      end
    end
  endtask

  task automatic modelUpd(input logic [13:0] p, input bit tk);
    bit pred, alt, done;
    int prov, i;
    modelLook(p, pred, prov, alt);
    evUse = 0; evAlloc = 0; evClr = 0;
    if (prov == 0) begin
      if (tk && mBase[p[7:0]] < 3) mBase[p[7:0]]++;
      else if (!tk && mBase[p[7:0]] > 0) mBase[p[7:0]]--;
    end else begin
      i = mIdx(p, prov - 1);
      if (tk && mCtr[prov-1][i] < 3) mCtr[prov-1][i]++;
      else if (!tk && mCtr[prov-1][i] > -4) mCtr[prov-1][i]--;
      if (pred == tk && alt != pred) begin mU[prov-1][i] = 1; evUse = 1; end
    end
    if (pred != tk && prov < 3) begin
      done = 0;
      for (int k = prov; k < 3; k++) begin
        i = mIdx(p, k);
        if (!done && !mU[k][i]) begin
          mVld[k][i] = 1; mU[k][i] = 0; mTag[k][i] = mTg(p, k);
          mCtr[k][i] = tk ? 0 : -1;
          done = 1; evAlloc = 1;
        end
      end
      if (!done) begin
        for (int k = prov; k < 3; k++) mU[k][mIdx(p, k)] = 0;
        evClr = 1;
      end
    end
    mGhr = {mGhr[14:0], tk};
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [13:0] p, input bit tk, input bit v);
    bit ePred, eAlt;
    int eProv;
    string lbl;
    @(negedge clk);
    pcWord = p; updTaken = tk; updValid = v;
    #1;
    modelLook(p, ePred, eProv, eAlt);
    lbl = (eProv == 0) ? "R1 R2 R4" : "R1 R2 R3 R6";
    if (evUse)   lbl = {lbl, " R7"};
    if (evAlloc) lbl = {lbl, " R8"};
    if (evClr)   lbl = {lbl, " R9"};
    check(predTaken == ePred && int'(provId) == eProv, lbl,
          int'({predTaken, provId}), (int'(ePred) << 2) | eProv);
    if (v) modelUpd(p, tk);
    else begin evUse = 0; evAlloc = 0; evClr = 0; end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit  hold;
    logic [1:0] holdProv;
    modelReset();
    evUse = 0; evAlloc = 0; evClr = 0;
    repeat (3) @(negedge clk);
    // R5: reset state
    pcWord = 14'h2a40; #1;
    check(predTaken == 1'b0 && provId == 2'd0, "R5", int'({predTaken, provId}), 0);
    @(negedge clk); rstN = 1'b1;

    // table walk
    for (int r = 0; r < 8; r++)
      for (int n = 0; n < 16; n++)
        step(VEC[n][14:1], VEC[n][0], 1'b1);

    // loop-like branch: taken three times, then not taken
    for (int n = 0; n < 240; n++) step(14'h0040, (n % 4) != 3, 1'b1);

    // alternating branches with crossing outcomes
    for (int n = 0; n < 240; n++) step(n[0] ? 14'h1f07 : 14'h2a40, n[1] ^ n[0], 1'b1);

    // R10: outcome toggles with no update strobe
    step(14'h0040, 1'b0, 1'b1);
    @(negedge clk); pcWord = 14'h0040; updValid = 1'b0; #1;
    hold = predTaken; holdProv = provId;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk); updTaken = n[0]; #1;
      check(predTaken == hold && provId == holdProv, "R10",
            int'({predTaken, provId}), int'({hold, holdProv}));
    end
    for (int n = 0; n < 40; n++) step(14'h0040, (n % 4) != 3, 1'b1);

    // R5: reset again after training
    @(negedge clk); updValid = 1'b0; rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    modelReset();
    pcWord = 14'h0040; #1;
    check(predTaken == 1'b0 && provId == 2'd0, "R5", int'({predTaken, provId}), 0);
    rstN = 1'b1;
    for (int n = 0; n < 64; n++) step(14'h0123 + 14'(n % 5), (n % 3) == 0, 1'b1);

    @(negedge clk); updValid = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule